// File: doc/BRIEF.md
# Serial Conversion Result Transmitter

This block sends a finished 14-bit converter result over a three-line serial link made of a serial clock, a data line and an active-low frame strobe. The serial clock comes from the converter master clock, divided by an even parameter. A pulse on the conversion-start input opens a frame. The strobe falls in that cycle. The block then shifts out sixteen bits: two zero pad bits come first, followed by the result with its most significant bit first. Each new bit is launched when the serial clock rises, and the receiver samples it when the serial clock falls.

All three lines act as open-drain outputs. Each line is modelled by an enable and a pull-low request. When the enable is low, the line is in high impedance. When the enable is high and the pull-low request is set, the line is driven low. In every other case an external pull-up holds the line high. A mode input selects how the serial clock behaves between frames. It can keep toggling with no gaps, or it can be released to high impedance so that several converters can share one bus.

Top module: `ser_result_tx`

## Requirements
- R1: While reset is asserted, the data and strobe lines are released (enable 0, pull-low 0) whatever conversion-start does, and no frame begins.
- R2: A frame carries 16 bits: two zero bits, then the 14-bit result, most significant bit first. A data level of 0 means the line is pulled low, and 1 means it is released.
- R3: While the strobe stays low, the data line changes only in a cycle where the serial clock goes from low to high.
- R4: A conversion-start pulse seen while idle pulls the strobe low in the next cycle. In that cycle the serial clock is high, and the first pad bit is on the data line for the first falling edge.
- R5: The strobe stays low for exactly 16 x DIV master-clock cycles. After that the strobe and data lines are both released together.
- R6: During a frame the serial clock is high for DIV/2 master cycles and then low for DIV/2 master cycles. A frame has exactly 16 falling edges.
- R7: In gated mode (mode input 0), the serial clock enable is 0 whenever no frame is in progress.
- R8: In free-running mode (mode input 1), the serial clock enable stays 1 and the clock keeps toggling between frames.
- R9: The result is captured when the frame starts. Changes to the result input and further conversion-start pulses during a frame have no effect on the word being sent.
- R10: No line ever requests pull-low while its enable is 0, and no line is ever driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | One-cycle pulse that starts a conversion and its frame |
| result | input | 14 | Conversion result to transmit |
| sck_free | input | 1 | 1: serial clock runs continuously; 0: released between frames |
| sck_oe | output | 1 | Serial clock output enable |
| sck_pd | output | 1 | Serial clock pull-low request |
| sdo_oe | output | 1 | Data line output enable |
| sdo_pd | output | 1 | Data line pull-low request |
| fs_oe | output | 1 | Frame strobe output enable |
| fs_pd | output | 1 | Frame strobe pull-low request |

## Verification
Several properties are checked on every cycle:
- the open-drain pairing of enable and pull-low;
- data and strobe being released together;
- data moving only on serial-clock rising edges;
- the strobe falling while the clock is high;
- the strobe-low window never exceeding its length, and ending at exactly that length;
- the serial clock enable following the selected mode.

The bench scenarios cover what only a whole frame can show. It rebuilds the word from the falling-edge samples and compares it with the pad bits and the result. It measures the high phase of the serial clock. It also shows that a new result and a second start pulse arriving mid-frame leave the word unchanged.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic {
        SCK_GATED = 1'b0,
        SCK_FREE  = 1'b1
    } sck_mode_e;

    // open-drain pad request: oe=0 -> high impedance, oe=1 & pd=1 -> low
    typedef struct packed {
        logic oe;
        logic pd;
    } od_drv_t;

    // Enable the pad and pull it low only for a 0 level.
    function automatic od_drv_t od_drive(input logic en, input logic level);
        od_drv_t d;
        d.oe = en;
        d.pd = en & ~level;
        return d;
    endfunction

endpackage

// File: rtl/ser_sck_div.sv
module ser_sck_div #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic sck_low,
    output logic wrap
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] HALF = PW'(DIV / 2);

    logic [PW-1:0] phase;

    // phase 0 is the serial clock rising edge; HALF is its falling edge
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    assign sck_low = (phase >= HALF);
    assign wrap    = (phase == LAST);
endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift #(
    parameter int unsigned RES_W    = 14,
    parameter int unsigned PAD_BITS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic [RES_W-1:0] result,
    input  logic             wrap,
    output logic             busy,
    output logic             cur_bit,
    output logic             start
);
    localparam int unsigned FW = RES_W + PAD_BITS;
    localparam int unsigned CW = $clog2(FW);
    localparam logic [CW-1:0] LASTB = CW'(FW - 1);

    logic [FW-1:0] shreg;
    logic [CW-1:0] bit_idx;

    // a start is only taken while idle; pulses inside a frame are dropped
    assign start = conv_start & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            shreg   <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            bit_idx <= '0;
            shreg   <= {{PAD_BITS{1'b0}}, result};
        end else if (busy && wrap) begin
            if (bit_idx == LASTB) begin
                busy <= 1'b0;
            end else begin
                bit_idx <= bit_idx + CW'(1);
                shreg   <= {shreg[FW-2:0], 1'b0};
            end
        end
    end

    assign cur_bit = shreg[FW-1];
endmodule

// File: rtl/ser_od_drive.sv
module ser_od_drive
    import ser_tx_pkg::*;
(
    input  logic      busy,
    input  logic      cur_bit,
    input  logic      sck_low,
    input  sck_mode_e mode,
    output od_drv_t   sck,
    output od_drv_t   dat,
    output od_drv_t   stb
);
    always_comb begin
        sck = od_drive(busy | (mode == SCK_FREE), ~sck_low);
        dat = od_drive(busy, cur_bit);
        stb = od_drive(busy, 1'b0);
    end
endmodule

// File: rtl/ser_result_tx.sv
module ser_result_tx
    import ser_tx_pkg::*;
#(
    parameter int unsigned RES_W    = 14,
    parameter int unsigned PAD_BITS = 2,
    parameter int unsigned DIV      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic [RES_W-1:0] result,
    input  logic             sck_free,
    output logic             sck_oe,
    output logic             sck_pd,
    output logic             sdo_oe,
    output logic             sdo_pd,
    output logic             fs_oe,
    output logic             fs_pd
);
    logic    busy, cur_bit, start, sck_low, wrap;
    od_drv_t sck_d, dat_d, stb_d;

    ser_sck_div #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .sck_low (sck_low),
        .wrap    (wrap)
    );

    ser_frame_shift #(.RES_W(RES_W), .PAD_BITS(PAD_BITS)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .conv_start (conv_start),
        .result     (result),
        .wrap       (wrap),
        .busy       (busy),
        .cur_bit    (cur_bit),
        .start      (start)
    );

    ser_od_drive u_pads (
        .busy    (busy),
        .cur_bit (cur_bit),
        .sck_low (sck_low),
        .mode    (sck_mode_e'(sck_free)),
        .sck     (sck_d),
        .dat     (dat_d),
        .stb     (stb_d)
    );

    assign sck_oe = sck_d.oe;
    assign sck_pd = sck_d.pd;
    assign sdo_oe = dat_d.oe;
    assign sdo_pd = dat_d.pd;
    assign fs_oe  = stb_d.oe;
    assign fs_pd  = stb_d.pd;
endmodule

// File: rtl/ser_result_tx_chk.sv
module ser_result_tx_chk #(
    parameter int unsigned RES_W    = 14,
    parameter int unsigned PAD_BITS = 2,
    parameter int unsigned DIV      = 2
) (
    input logic clk,
    input logic rst,
    input logic sck_free,
    input logic sck_oe,
    input logic sck_pd,
    input logic sdo_oe,
    input logic sdo_pd,
    input logic fs_oe,
    input logic fs_pd
);
    localparam int unsigned FRAME_CYC = (RES_W + PAD_BITS) * DIV;

    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst) low_run <= 0;
        else if (fs_pd) low_run <= low_run + 1;
        else low_run <= 0;
    end

    a_r10_pd_needs_oe: assert property (@(posedge clk) disable iff (rst)
        !((sck_pd && !sck_oe) || (sdo_pd && !sdo_oe) || (fs_pd && !fs_oe)));

    a_r5_data_with_strobe: assert property (@(posedge clk) disable iff (rst)
        sdo_oe == fs_oe);

    a_r7_gated_release: assert property (@(posedge clk) disable iff (rst)
        (!sck_free && !fs_oe) |-> !sck_oe);

    a_r8_free_enabled: assert property (@(posedge clk) disable iff (rst)
        sck_free |-> sck_oe);

    a_r3_data_on_rise: assert property (@(posedge clk) disable iff (rst)
        (fs_pd && $past(fs_pd) && (sdo_pd != $past(sdo_pd)))
        |-> ($past(sck_pd) && !sck_pd));

    a_r4_strobe_sck_high: assert property (@(posedge clk) disable iff (rst)
        $rose(fs_pd) |-> !sck_pd);

    a_r5_window_bound: assert property (@(posedge clk) disable iff (rst)
        fs_pd |-> (low_run < FRAME_CYC));

    a_r5_window_exact: assert property (@(posedge clk) disable iff (rst)
        (!fs_pd && low_run != 0) |-> (low_run == FRAME_CYC));
endmodule

bind ser_result_tx ser_result_tx_chk #(
    .RES_W(RES_W), .PAD_BITS(PAD_BITS), .DIV(DIV)
) u_chk (
    .clk(clk), .rst(rst), .sck_free(sck_free),
    .sck_oe(sck_oe), .sck_pd(sck_pd),
    .sdo_oe(sdo_oe), .sdo_pd(sdo_pd),
    .fs_oe(fs_oe), .fs_pd(fs_pd)
);

// File: tb/tb_ser_result_tx.sv
module tb_ser_result_tx;
    localparam int DIV  = 2;
    localparam int RW   = 14;
    localparam int PB   = 2;
    localparam int FW   = RW + PB;
    localparam int FCYC = FW * DIV;
    localparam int HALF = DIV / 2;

    logic          clk = 1'b0;
    logic          rst, conv_start, sck_free;
    logic [RW-1:0] result;
    logic          sck_oe, sck_pd, sdo_oe, sdo_pd, fs_oe, fs_pd;
    logic          sck_lvl, dat_lvl, fs_lvl;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    ser_result_tx #(.RES_W(RW), .PAD_BITS(PB), .DIV(DIV)) dut (
        .clk(clk), .rst(rst), .conv_start(conv_start), .result(result),
        .sck_free(sck_free),
        .sck_oe(sck_oe), .sck_pd(sck_pd),
        .sdo_oe(sdo_oe), .sdo_pd(sdo_pd),
        .fs_oe(fs_oe), .fs_pd(fs_pd)
    );

    // line level seen with a pull-up
    assign sck_lvl = !(sck_oe && sck_pd);
    assign dat_lvl = !(sdo_oe && sdo_pd);
    assign fs_lvl  = !(fs_oe && fs_pd);

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [RW-1:0] val, input bit disturb);
        logic [FW-1:0] word;
        int  nbits, lows, hirun, guard;
        bit  r3ok, r6ok, r10ok, poked, psck, pdat;
        @(negedge clk);
        result     = val;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        chk(fs_lvl == 1'b0, "R4 strobe low after start", 32'(fs_lvl), 0);
        chk(sck_lvl == 1'b1, "R4 sclk high at frame start", 32'(sck_lvl), 1);
        word = '0; nbits = 0; lows = 1; hirun = 1; guard = 0;
        r3ok = 1; r6ok = 1; r10ok = 1; poked = 0;
        psck = sck_lvl; pdat = dat_lvl;
        while (fs_lvl == 1'b0 && guard < 4 * FCYC) begin
            @(negedge clk);
            guard++;
            if (conv_start) conv_start = 1'b0;
            if ((sck_pd && !sck_oe) || (sdo_pd && !sdo_oe) || (fs_pd && !fs_oe))
                r10ok = 0;
            if (fs_lvl == 1'b0) begin
                lows++;
                if (psck && !sck_lvl) begin
                    word = {word[FW-2:0], dat_lvl};
                    nbits++;
                    if (hirun != HALF) r6ok = 0;
                end
                if (sck_lvl) hirun = psck ? hirun + 1 : 1;
                if (dat_lvl != pdat && !(!psck && sck_lvl)) r3ok = 0;
                if (disturb && !poked && nbits == 5) begin
                    poked      = 1;
                    result     = ~val;
                    conv_start = 1'b1;
                end
                psck = sck_lvl;
                pdat = dat_lvl;
            end
        end
        chk(lows == FCYC, "R5 strobe low length", 32'(lows), 32'(FCYC));
        chk(!sdo_oe && !sdo_pd && !fs_oe, "R5 data and strobe released",
            {29'd0, sdo_oe, sdo_pd, fs_oe}, 0);
        chk(nbits == FW, "R6 falling edges per frame", 32'(nbits), 32'(FW));
        chk(r6ok, "R6 sclk high phase length", 32'(r6ok), 1);
        chk(word === {{PB{1'b0}}, val}, disturb ? "R9 word kept despite mid-frame changes"
                                                : "R2 frame word",
            32'(word), 32'({{PB{1'b0}}, val}));
        chk(r3ok, "R3 data changes only on sclk rise", 32'(r3ok), 1);
        chk(r10ok, "R10 pull-low only when enabled", 32'(r10ok), 1);
        if (sck_free) chk(sck_oe == 1'b1, "R8 sclk enabled after frame", 32'(sck_oe), 1);
        else          chk(sck_oe == 1'b0, "R7 sclk released after frame", 32'(sck_oe), 0);
    endtask

    task automatic idle(input int n);
        bit gated_ok;
        int tog;
        bit p;
        gated_ok = 1; tog = 0;
        @(negedge clk);
        p = sck_lvl;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sck_oe) gated_ok = 0;
            if (sck_lvl != p) tog++;
            p = sck_lvl;
        end
        if (sck_free) chk(tog >= 2 * (n / DIV) - 2, "R8 sclk toggles while idle",
                          32'(tog), 32'(2 * (n / DIV) - 2));
        else          chk(gated_ok, "R7 sclk high impedance while idle", 32'(gated_ok), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        rst = 1'b1; conv_start = 1'b1; sck_free = 1'b0; result = 14'h3FFF;
        repeat (3) @(negedge clk);
        chk(!fs_oe && !fs_pd, "R1 strobe released in reset", {30'd0, fs_oe, fs_pd}, 0);
        chk(!sdo_oe && !sdo_pd, "R1 data released in reset", {30'd0, sdo_oe, sdo_pd}, 0);
        chk(!sck_oe, "R1 gated sclk released in reset", 32'(sck_oe), 0);
        conv_start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fs_lvl == 1'b1, "R1 no frame after reset", 32'(fs_lvl), 1);
        x = 32'h1234_5678;
        for (int m = 0; m < 2; m++) begin
            sck_free = m[0];
            idle(6);
            run_frame(14'h0000, 0);
            run_frame(14'h3FFF, 0);
            run_frame(14'h2AAA, 0);
            run_frame(14'h1555, 0);
            run_frame(14'h0001, 0);
            run_frame(14'h2000, 0);
            for (int k = 0; k < 40; k++) begin
                x = x * 32'd1103515245 + 32'd12345;
                run_frame(x[29:16], 0);
                if (k % 8 == 0) idle(5);
            end
            run_frame(14'h1A5C, 1);
            idle(6);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule